// File: doc/BRIEF.md
# Control-Port Byte-Link Master

This block is the master end of a half-duplex byte link that carries register reads and writes. It takes one single-cycle request from a local control port: a write or read strobe, a 20-bit address and 32-bit write data. It sends the request as a short burst of bytes, then hands the link to the remote slave by raising a direction line. It gathers the response bytes and answers the local port with a one-cycle acknowledge, a 2-bit status and, for reads, 32-bit data.

The most significant bit of the first request byte selects the frame lengths. A write sends 6 bytes and expects 1 response byte. A read sends 2 bytes and expects 5. The master can cut off a slave that never answers: a timeout counter runs while the link is turned around, and when it expires the master drops the direction line and reports an error.

The control FSM has five states:

- `ST_IDLE`: waits for a request. A write or read strobe moves it to `ST_GAP`.
- `ST_GAP`: one quiet cycle with the direction line low. It always moves to `ST_SEND`.
- `ST_SEND`: drives one byte per cycle. After the last request byte it moves to `ST_WAIT`.
- `ST_WAIT`: the direction line is high and response bytes are collected. It moves to `ST_RESP` on the final response byte or when the timer expires.
- `ST_RESP`: the acknowledge cycle. It always moves to `ST_IDLE`.

Top module: `cpbyte_master`

## Requirements
- R1: While reset is applied and in the first cycle after it, `link_dir`, `link_tx_valid` and `resp_ack` are all 0.
- R2: A write request sends exactly 6 bytes on consecutive cycles, in this order:
  - first byte: {1, addr[14:8]};
  - second byte: addr[7:0];
  - then data[31:24], data[23:16], data[15:8] and data[7:0].
  - Address bits [19:15] are never sent.
- R3: A read request sends exactly 2 bytes on consecutive cycles: {0, addr[14:8]} and then addr[7:0].
- R4: The first request byte is valid in the second cycle after the clock edge that samples the request. The cycle before it has `link_tx_valid` low and `link_dir` low.
- R5: `link_dir` goes high in the cycle right after the last request byte. It stays high until the response completes or the timer expires. `link_tx_valid` is never high while `link_dir` is high.
- R6: A write response is one status byte with bits [7:3] = 0, bit 2 = 1 (the marker) and bits [1:0] = status. `resp_ack` is high in the cycle after the edge that captures that byte. At the same time `resp_status` equals bits [1:0], `resp_data` is 0 and `link_dir` is already low.
- R7: A read response is 5 bytes: the read data most significant byte first, then the status byte laid out as in R6. `resp_data` carries the 32 data bits with the acknowledge.
- R8: If the marker bit (bit 2) of the status byte is 0, `resp_status` is 2'b11, whatever bits [1:0] hold.
- R9: If the response is incomplete after `TIMEOUT_CYCLES` cycles with `link_dir` high, the master does three things in the next cycle:
  - lowers `link_dir`;
  - pulses `resp_ack` with status 2'b11 and data 0;
  - returns to idle.
- R10: `resp_ack` lasts exactly one cycle. A strobe that arrives while a transaction is in progress, including the acknowledge cycle, causes no bytes, no acknowledge and no change to the frame in flight.
- R11: If `req_wr` and `req_rd` are high together, the request is treated as a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_wr | input | 1 | Single-cycle write strobe |
| req_rd | input | 1 | Single-cycle read strobe |
| req_addr | input | 20 | Register address; bits [14:0] are sent |
| req_data | input | 32 | Write data |
| resp_ack | output | 1 | One-cycle completion pulse |
| resp_status | output | 2 | Response status; 2'b11 on timeout or bad marker |
| resp_data | output | 32 | Read data; 0 for writes and timeouts |
| link_tx_data | output | 8 | Request byte towards the slave |
| link_tx_valid | output | 1 | Request byte valid |
| link_dir | output | 1 | 1 = slave owns the link (response phase) |
| link_rx_data | input | 8 | Response byte from the slave |
| link_rx_valid | input | 1 | Response byte valid |

## Verification
The bench drives all inputs and samples all outputs on the falling edge. Each result therefore has a fixed falling edge at which it must appear:

- The first falling edge after a request is the quiet cycle.
- The next falling edge shows the first request byte.
- `link_dir` must read high on the falling edge right after the last valid byte.
- The acknowledge must appear on the falling edge directly after the one at which the final response byte was driven.
- On a timeout, `link_dir` must read high on exactly `TIMEOUT_CYCLES` falling edges, with the acknowledge on the edge after those.

Each check waits for its own edge rather than polling for a result. A late or early output is therefore reported as a mismatch.

// File: rtl/cpbyte_pkg.sv
package cpbyte_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_SEND,
        ST_WAIT,
        ST_RESP
    } cpb_state_t;

    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 20;
    localparam int SENT_ADDR_W  = 15;
    localparam int WR_REQ_BYTES = 6;
    localparam int RD_REQ_BYTES = 2;
    localparam int WR_RSP_BYTES = 1;
    localparam int RD_RSP_BYTES = 5;
    localparam int MARKER_BIT   = 2;
    localparam logic [1:0] STATUS_ERR = 2'b11;
endpackage

// File: rtl/cpbyte_tx_shift.sv
module cpbyte_tx_shift #(
    parameter int BYTES = 6,
    localparam int FW = BYTES * 8,
    localparam int CW = $clog2(BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [FW-1:0] frame,
    input  logic          shift,
    output logic [7:0]    head,
    output logic [CW-1:0] sent
);
    logic [FW-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            sent <= '0;
        end else if (load) begin
            sr   <= frame;
            sent <= '0;
        end else if (shift) begin
            sr   <= {sr[FW-9:0], 8'h00};
            sent <= sent + 1'b1;
        end
    end

    assign head = sr[FW-1 -: 8];

    // R2
    sent_bound_chk: assert property (@(posedge clk) disable iff (rst)
        sent <= CW'(BYTES));
endmodule

// File: rtl/cpbyte_rx_collect.sv
module cpbyte_rx_collect #(
    parameter int BYTES = 5,
    localparam int FW = BYTES * 8,
    localparam int CW = $clog2(BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          take,
    input  logic [7:0]    din,
    output logic [FW-1:0] held,
    output logic [CW-1:0] got
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            held <= '0;
            got  <= '0;
        end else if (take) begin
            held <= {held[FW-9:0], din};
            got  <= got + 1'b1;
        end
    end

    // R7
    got_bound_chk: assert property (@(posedge clk) disable iff (rst)
        got <= CW'(BYTES));
endmodule

// File: rtl/cpbyte_timeout.sv
module cpbyte_timeout #(
    parameter int LIMIT = 256,
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == CW'(LIMIT - 1));

    // R9
    timer_limit_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(LIMIT - 1));
endmodule

// File: rtl/cpbyte_master.sv
module cpbyte_master
    import cpbyte_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_wr,
    input  logic        req_rd,
    input  logic [19:0] req_addr,
    input  logic [31:0] req_data,
    output logic        resp_ack,
    output logic [1:0]  resp_status,
    output logic [31:0] resp_data,
    output logic [7:0]  link_tx_data,
    output logic        link_tx_valid,
    output logic        link_dir,
    input  logic [7:0]  link_rx_data,
    input  logic        link_rx_valid
);
    localparam int TX_FW = WR_REQ_BYTES * 8;
    localparam int RX_FW = RD_RSP_BYTES * 8;
    localparam int TX_CW = $clog2(WR_REQ_BYTES + 1);
    localparam int RX_CW = $clog2(RD_RSP_BYTES + 1);

    cpb_state_t state, state_nx;
    logic is_write;
    logic timed_out;
    logic accept;
    logic tx_last;
    logic rx_last;
    logic expired;
    logic [7:0] tx_head;
    logic [TX_CW-1:0] tx_sent;
    logic [RX_FW-1:0] rx_held;
    logic [RX_CW-1:0] rx_got;
    logic [TX_CW-1:0] tx_need;
    logic [RX_CW-1:0] rx_need;
    logic [7:0] status_byte;
    logic unused_addr_hi;

    assign unused_addr_hi = ^req_addr[ADDR_W-1:SENT_ADDR_W];

    assign accept  = (state == ST_IDLE) && (req_wr || req_rd);
    assign tx_need = is_write ? TX_CW'(WR_REQ_BYTES) : TX_CW'(RD_REQ_BYTES);
    assign rx_need = is_write ? RX_CW'(WR_RSP_BYTES) : RX_CW'(RD_RSP_BYTES);
    assign tx_last = (tx_sent == tx_need - 1'b1);
    assign rx_last = link_rx_valid && (rx_got == rx_need - 1'b1);

    cpbyte_tx_shift #(.BYTES(WR_REQ_BYTES)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .frame ({req_wr, req_addr[SENT_ADDR_W-1:0], req_data}),
        .shift (state == ST_SEND),
        .head  (tx_head),
        .sent  (tx_sent)
    );

    cpbyte_rx_collect #(.BYTES(RD_RSP_BYTES)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .take  ((state == ST_WAIT) && link_rx_valid),
        .din   (link_rx_data),
        .held  (rx_held),
        .got   (rx_got)
    );

    cpbyte_timeout #(.LIMIT(TIMEOUT_CYCLES)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_WAIT),
        .expired (expired)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_GAP;
            ST_GAP:  state_nx = ST_SEND;
            ST_SEND: if (tx_last) state_nx = ST_WAIT;
            ST_WAIT: if (rx_last || expired) state_nx = ST_RESP;
            ST_RESP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            is_write  <= 1'b0;
            timed_out <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                is_write  <= req_wr;
                timed_out <= 1'b0;
            end else if (state == ST_WAIT && !rx_last && expired) begin
                timed_out <= 1'b1;
            end
        end
    end

    assign status_byte = rx_held[7:0];

    always_comb begin
        link_tx_valid = (state == ST_SEND);
        link_tx_data  = link_tx_valid ? tx_head : 8'h00;
        link_dir      = (state == ST_WAIT);
        resp_ack      = (state == ST_RESP);
        resp_status   = 2'b00;
        resp_data     = '0;
        if (resp_ack) begin
            if (timed_out || !status_byte[MARKER_BIT]) begin
                resp_status = STATUS_ERR;
            end else begin
                resp_status = status_byte[1:0];
            end
            if (!timed_out && !is_write) begin
                resp_data = rx_held[RX_FW-1:8];
            end
        end
    end

    // R5
    tx_quiet_when_turned_chk: assert property (@(posedge clk) disable iff (rst)
        link_tx_valid |-> !link_dir);

    // R4
    gap_before_first_byte_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(link_tx_valid) |-> !$past(link_dir));

    // R10
    ack_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        resp_ack |=> !resp_ack);

    // R9
    dir_release_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(link_dir) |-> resp_ack);

    // R5
    dir_after_last_byte_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(link_tx_valid) |-> link_dir);
endmodule

// File: tb/cpbyte_master_test.sv
`timescale 1ns/1ps
module cpbyte_master_test;
    localparam int TMO = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_wr = 1'b0;
    logic        req_rd = 1'b0;
    logic [19:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic        resp_ack;
    logic [1:0]  resp_status;
    logic [31:0] resp_data;
    logic [7:0]  link_tx_data;
    logic        link_tx_valid;
    logic        link_dir;
    logic [7:0]  link_rx_data = '0;
    logic        link_rx_valid = 1'b0;

    int checks = 0;
    int fails = 0;
    logic [7:0] cap [0:7];
    int cap_n;

    always #2.5 clk = ~clk;

    cpbyte_master #(.TIMEOUT_CYCLES(TMO)) uut (
        .clk(clk), .rst(rst), .req_wr(req_wr), .req_rd(req_rd),
        .req_addr(req_addr), .req_data(req_data), .resp_ack(resp_ack),
        .resp_status(resp_status), .resp_data(resp_data),
        .link_tx_data(link_tx_data), .link_tx_valid(link_tx_valid),
        .link_dir(link_dir), .link_rx_data(link_rx_data),
        .link_rx_valid(link_rx_valid)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive a strobe for one cycle; on return the quiet gap cycle is visible.
    task automatic issue(bit wr, bit rd, logic [19:0] a, logic [31:0] d);
        @(negedge clk);
        req_wr = wr; req_rd = rd; req_addr = a; req_data = d;
        @(negedge clk);
        req_wr = 1'b0; req_rd = 1'b0;
        check("R4 gap valid low", link_tx_valid, 0);
        check("R4 gap dir low", link_dir, 0);
    endtask

    // Collect request bytes until the link turns; ends on first dir-high edge.
    task automatic capture(bit inject_busy);
        bit prev_valid = 1'b0;
        cap_n = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (inject_busy && i == 1) begin
                req_rd = 1'b1; req_addr = 20'h00777;
            end else if (inject_busy && i == 2) begin
                req_rd = 1'b0;
            end
            if (i == 0) check("R4 first byte due", link_tx_valid, 1);
            if (link_dir) begin
                check("R5 dir right after last byte", prev_valid, 1);
                break;
            end
            if (link_tx_valid && cap_n < 8) begin
                cap[cap_n] = link_tx_data;
                cap_n++;
            end
            prev_valid = link_tx_valid;
        end
    endtask

    task automatic respond(logic [39:0] bytes, int n);
        for (int i = 0; i < n; i++) begin
            check("R5 dir held", link_dir, 1);
            link_rx_valid = 1'b1;
            link_rx_data = bytes[39 - 8*i -: 8];
            @(negedge clk);
        end
        link_rx_valid = 1'b0;
        link_rx_data = 8'h00;
    endtask

    task automatic expect_ack(string req, logic [1:0] st, logic [31:0] d);
        check({req, " ack"}, resp_ack, 1);
        check({req, " status"}, resp_status, st);
        check({req, " data"}, resp_data, d);
        check({req, " dir low at ack"}, link_dir, 0);
        @(negedge clk);
        check("R10 ack one cycle", resp_ack, 0);
    endtask

    task automatic t_reset();
        check("R1 dir", link_dir, 0);
        check("R1 tx_valid", link_tx_valid, 0);
        check("R1 ack", resp_ack, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 dir after", link_dir, 0);
        check("R1 ack after", resp_ack, 0);
    endtask

    task automatic t_write();
        issue(1, 0, 20'hFABCD, 32'h12345678);
        capture(0);
        check("R2 count", cap_n, 6);
        check("R2 frame", {cap[0], cap[1], cap[2], cap[3], cap[4], cap[5]},
              48'hABCD_1234_5678);
        respond(40'h05_00000000, 1);
        expect_ack("R6 write", 2'b01, 32'h0);
    endtask

    task automatic t_read();
        issue(0, 1, 20'h80123, 32'hFFFFFFFF);
        capture(0);
        check("R3 count", cap_n, 2);
        check("R3 frame", {cap[0], cap[1]}, 16'h0123);
        repeat (3) begin
            @(negedge clk);
            check("R5 dir held while slave idle", link_dir, 1);
        end
        respond(40'hDEADBEEF_06, 5);
        expect_ack("R7 read", 2'b10, 32'hDEADBEEF);
    endtask

    task automatic t_marker();
        issue(0, 1, 20'h00042, 32'h0);
        capture(0);
        respond(40'h01020304_01, 5);
        expect_ack("R8 bad marker", 2'b11, 32'h01020304);
        issue(1, 0, 20'h00042, 32'hA5A5A5A5);
        capture(0);
        respond(40'h02_00000000, 1);
        expect_ack("R8 write bad marker", 2'b11, 32'h0);
    endtask

    task automatic t_timeout(int partial);
        int high = 1;
        issue(0, 1, 20'h00100, 32'h0);
        capture(0);
        if (partial > 0) begin
            respond(40'hAABBCCDD_00, partial);
            high += partial;
        end
        for (int i = 0; i < 3 * TMO && link_dir; i++) begin
            @(negedge clk);
            if (link_dir) high++;
        end
        check("R9 dir high cycles", high, TMO);
        expect_ack("R9 timeout", 2'b11, 32'h0);
    endtask

    task automatic t_busy();
        issue(1, 0, 20'h01234, 32'hCAFEF00D);
        capture(1);
        check("R10 busy count", cap_n, 6);
        check("R10 busy frame", {cap[0], cap[1], cap[2], cap[3], cap[4], cap[5]},
              48'h9234_CAFE_F00D);
        respond(40'h04_00000000, 1);
        check("R10 ack", resp_ack, 1);
        req_wr = 1'b1;
        @(negedge clk);
        req_wr = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check("R10 no bytes after late strobe", link_tx_valid, 0);
            check("R10 no ack after late strobe", resp_ack, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_both();
        issue(1, 1, 20'h07F01, 32'h00000001);
        capture(0);
        check("R11 count", cap_n, 6);
        check("R11 first byte", cap[0], 8'hFF);
        respond(40'h07_00000000, 1);
        expect_ack("R11 ack", 2'b11, 32'h0);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_marker();
        t_timeout(0);
        t_timeout(2);
        t_busy();
        t_both();
        t_write();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule